// File: doc/BRIEF.md
# Receive FIFO with Level Trigger and Stale-Data Timeout

This block holds received characters between a serial deserializer and a host. The deserializer hands over one byte per cycle through a valid strobe. The host sees the oldest byte at a read port and removes it with a pop strobe. A control write selects one of two modes. In queue mode the block stores up to sixteen bytes. In holding mode it stores exactly one. The same control write can also discard everything that is stored.

Two requests go to the host. The level request is active while the number of stored bytes is at or above a programmable threshold. The stale request is active when stored bytes have gone untouched for four character times. A character time is sixteen baud ticks for each of ten bit periods. The stale counter restarts on every accepted load and every host pop, and it stays idle while nothing is stored. A load that finds no room is dropped, and a sticky overrun flag records the loss.

Top module: `rxq_top`

## Requirements
- R1: While reset is held and right after it is released, the store is empty, `rd_ready`, `rd_byte`, `irq_level`, `irq_stale` and `ovr_flag` are all 0, and holding mode is selected.
- R2: With control bit 0 set (queue mode), up to 16 bytes are stored. `rd_byte` shows the oldest stored byte while `rd_ready` is 1, and pops return bytes in arrival order. `rd_byte` reads 0 when the store is empty.
- R3: A load that arrives when the store is at capacity (16 in queue mode, 1 in holding mode) and is not paired with a pop is dropped. The stored contents are unchanged, and `ovr_flag` goes to 1 and stays there until a flush.
- R4: Control bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In holding mode the threshold is 1. `irq_level` is 1 in the cycle after the stored count first reaches the threshold.
- R5: `irq_level` stays 1 while the count is at or above the threshold, and it drops to 0 once a pop takes the count below the threshold.
- R6: When the store is not empty and 640 baud ticks pass with no accepted load or pop, `irq_stale` goes to 1 in the cycle after the 640th tick. It holds at 1 until a load, a pop or a flush.
- R7: Every accepted load and every pop resets the stale counter to zero and clears `irq_stale` in the next cycle.
- R8: While the store is empty, baud ticks are not counted and `irq_stale` stays 0.
- R9: A control write with bit 1 set, or one that changes bit 0, empties the store and clears `ovr_flag` and `irq_stale`. Bit 1 is not retained. A load in the same cycle as a flush is discarded and does not set overrun.
- R10: A pop while the store is empty has no effect. A load paired with a pop while the store is full is accepted, and the count stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: bit 0 selects queue mode, bit 1 requests a flush, bits 7:6 select the threshold |
| rx_vld | input | 1 | Load strobe from the deserializer |
| rx_byte | input | 8 | Byte to load |
| baud_tick | input | 1 | One pulse per baud sub-tick (16 per bit) |
| rd_pop | input | 1 | Host pop strobe |
| rd_byte | output | 8 | Oldest stored byte, or 0 when empty |
| rd_ready | output | 1 | At least one byte is stored |
| irq_level | output | 1 | Count is at or above the threshold |
| irq_stale | output | 1 | Stored data has been untouched for the timeout window |
| ovr_flag | output | 1 | Sticky flag: a byte was dropped |

## Verification
The bench targets the threshold edge at counts 13 and 14 and at counts 7 and 8. A design that compares off by one would raise `irq_level` one byte early or one byte late. It targets a load paired with a pop on a full store, which an overly strict full test would wrongly drop with overrun set. It also targets the 640th tick of the stale window, where a counter with the wrong limit or one that never restarts on a pop would fire a cycle early, a cycle late, or right after service. Finally, it checks that the mode-change flush and holding mode both give a capacity of one and a threshold of one. A design that kept stale queue contents after the switch would be caught.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Control word field positions
  localparam int unsigned CTL_QMODE_BIT = 0;
  localparam int unsigned CTL_FLUSH_BIT = 1;
  localparam int unsigned CTL_TRIG_LSB  = 6;
  localparam int unsigned CTL_TRIG_MSB  = 7;

  typedef enum logic [1:0] {
    TRIG_ONE     = 2'b00,
    TRIG_QUARTER = 2'b01,
    TRIG_HALF    = 2'b10,
    TRIG_NEAR    = 2'b11
  } trig_sel_e;

  typedef struct packed {
    logic      qmode;
    trig_sel_e trig;
  } rxq_cfg_t;

  // Threshold in bytes for a given selection and store depth
  function automatic int unsigned trig_bytes(trig_sel_e sel, int unsigned depth);
    case (sel)
      TRIG_ONE:     return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output rxq_cfg_t   cfg,
  output logic       flush
);

  rxq_cfg_t cfg_q, cfg_d;
  logic     unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wdata[5:2];

  always_comb begin
    cfg_d = cfg_q;
    if (ctl_wr) begin
      cfg_d.qmode = ctl_wdata[CTL_QMODE_BIT];
      cfg_d.trig  = trig_sel_e'(ctl_wdata[CTL_TRIG_MSB:CTL_TRIG_LSB]);
    end
  end

  assign flush = ctl_wr &
                 (ctl_wdata[CTL_FLUSH_BIT] | (ctl_wdata[CTL_QMODE_BIT] != cfg_q.qmode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{qmode: 1'b0, trig: TRIG_ONE};
    end else if (ctl_wr) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cap_one,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    count,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    cap;
  logic             full, empty;

  assign cap   = cap_one ? CW'(1) : CW'(DEPTH);
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q >= cap);

  assign pop_ok  = pop & ~empty & ~flush;
  assign push_ok = push & ~flush & (~full | pop_ok);
  assign drop    = push & ~flush & ~push_ok;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_d = rd_ptr_q + AW'(1);
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array: no reset, written only on accepted loads
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= push_data;
    end
  end

  assign head_data = empty ? '0 : mem_q[rd_ptr_q];
  assign count     = cnt_q;

endmodule

// File: rtl/rxq_stale_timer.sv
module rxq_stale_timer #(
  parameter int unsigned LIMIT = 640,
  localparam int unsigned TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic idle,
  output logic expired
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == TW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || idle) begin
      cnt_d = '0;
    end else if (tick && !at_limit) begin
      cnt_d = cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = at_limit;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned TO_CHARS   = 4,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned CHAR_BITS  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic             rx_vld,
  input  logic [WIDTH-1:0] rx_byte,
  input  logic             baud_tick,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_byte,
  output logic             rd_ready,
  output logic             irq_level,
  output logic             irq_stale,
  output logic             ovr_flag
);

  localparam int unsigned CW        = $clog2(DEPTH + 1);
  localparam int unsigned TO_TICKS  = TO_CHARS * OVERSAMPLE * CHAR_BITS;
  localparam int unsigned LVL_ONE   = trig_bytes(TRIG_ONE, DEPTH);
  localparam int unsigned LVL_QTR   = trig_bytes(TRIG_QUARTER, DEPTH);
  localparam int unsigned LVL_HALF  = trig_bytes(TRIG_HALF, DEPTH);
  localparam int unsigned LVL_NEAR  = trig_bytes(TRIG_NEAR, DEPTH);

  rxq_cfg_t      cfg;
  logic          flush;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok, drop;
  logic [CW-1:0] lvl_sel;
  logic          ovr_q, ovr_d;

  rxq_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .cfg       (cfg),
    .flush     (flush)
  );

  rxq_store #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cap_one   (~cfg.qmode),
    .push      (rx_vld),
    .push_data (rx_byte),
    .pop       (rd_pop),
    .head_data (rd_byte),
    .count     (count),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .drop      (drop)
  );

  rxq_stale_timer #(
    .LIMIT (TO_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .restart (push_ok | pop_ok | flush),
    .idle    (count == '0),
    .expired (irq_stale)
  );

  always_comb begin
    if (!cfg.qmode) begin
      lvl_sel = CW'(LVL_ONE);
    end else begin
      unique case (cfg.trig)
        TRIG_ONE:     lvl_sel = CW'(LVL_ONE);
        TRIG_QUARTER: lvl_sel = CW'(LVL_QTR);
        TRIG_HALF:    lvl_sel = CW'(LVL_HALF);
        default:      lvl_sel = CW'(LVL_NEAR);
      endcase
    end
  end

  assign irq_level = (count >= lvl_sel);
  assign rd_ready  = (count != '0);

  always_comb begin
    ovr_d = ovr_q;
    if (flush)     ovr_d = 1'b0;
    else if (drop) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  assign ovr_flag = ovr_q;

endmodule

// File: rtl/rxq_top_chk.sv
module rxq_top_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [7:0]       ctl_wdata,
  input logic             rx_vld,
  input logic [WIDTH-1:0] rx_byte,
  input logic             baud_tick,
  input logic             rd_pop,
  input logic [WIDTH-1:0] rd_byte,
  input logic             rd_ready,
  input logic             irq_level,
  input logic             irq_stale,
  input logic             ovr_flag
);

  // R2: an empty store presents zero on the read port
  assert_empty_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> (rd_byte == '0));

  // R3: overrun persists until a control write
  assert_ovr_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ctl_wr |=> ovr_flag);

  // R3: overrun only rises after a load attempt
  assert_ovr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rx_vld));

  // R4: a level request needs stored data
  assert_level_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> rd_ready);

  // R7: serving a pop clears the stale request
  assert_pop_clears_stale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && rd_ready |=> !irq_stale);

  // R8: no stale request while empty
  assert_stale_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stale |-> rd_ready);

  // R9: explicit flush empties and clears flags
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[1] |=> !rd_ready && !ovr_flag && !irq_stale);

  // R10: empty stays empty without a load
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready && !rx_vld |=> !rd_ready);

endmodule

bind rxq_top rxq_top_chk #(.WIDTH(WIDTH)) u_rxq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .rx_vld    (rx_vld),
  .rx_byte   (rx_byte),
  .baud_tick (baud_tick),
  .rd_pop    (rd_pop),
  .rd_byte   (rd_byte),
  .rd_ready  (rd_ready),
  .irq_level (irq_level),
  .irq_stale (irq_stale),
  .ovr_flag  (ovr_flag)
);

// File: tb/tb_rxq_top.sv
module tb_rxq_top;

  localparam logic [1:0] OP_PUSH = 2'd0;
  localparam logic [1:0] OP_POP  = 2'd1;
  localparam logic [1:0] OP_BOTH = 2'd2;
  localparam logic [1:0] OP_CTL  = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] din;
    logic       rdy;
    logic [7:0] head;
    logic       lvl;
    logic       ovr;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{OP_CTL,  8'h41, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_PUSH, 8'hA1, 1'b1, 8'hA1, 1'b0, 1'b0},
    '{OP_PUSH, 8'hB2, 1'b1, 8'hA1, 1'b0, 1'b0},
    '{OP_PUSH, 8'hC3, 1'b1, 8'hA1, 1'b0, 1'b0},
    '{OP_PUSH, 8'hD4, 1'b1, 8'hA1, 1'b1, 1'b0},
    '{OP_POP,  8'h00, 1'b1, 8'hB2, 1'b0, 1'b0},
    '{OP_BOTH, 8'hE5, 1'b1, 8'hC3, 1'b0, 1'b0},
    '{OP_PUSH, 8'hF6, 1'b1, 8'hC3, 1'b1, 1'b0},
    '{OP_POP,  8'h00, 1'b1, 8'hD4, 1'b0, 1'b0},
    '{OP_POP,  8'h00, 1'b1, 8'hE5, 1'b0, 1'b0},
    '{OP_POP,  8'h00, 1'b1, 8'hF6, 1'b0, 1'b0},
    '{OP_POP,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_POP,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_CTL,  8'h01, 1'b0, 8'h00, 1'b0, 1'b0},
    '{OP_PUSH, 8'h77, 1'b1, 8'h77, 1'b1, 1'b0},
    '{OP_CTL,  8'h03, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic       rx_vld;
  logic [7:0] rx_byte;
  logic       baud_tick;
  logic       rd_pop;
  logic [7:0] rd_byte;
  logic       rd_ready;
  logic       irq_level;
  logic       irq_stale;
  logic       ovr_flag;

  int total;
  int bad;
  bit done;

  rxq_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .baud_tick (baud_tick),
    .rd_pop    (rd_pop),
    .rd_byte   (rd_byte),
    .rd_ready  (rd_ready),
    .irq_level (irq_level),
    .irq_stale (irq_stale),
    .ovr_flag  (ovr_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock cycle with the given strobes, then inputs return to idle
  task automatic step(input logic push, input logic [7:0] d, input logic pop,
                      input logic cw, input logic [7:0] cd, input logic tk);
    rx_vld = push; rx_byte = d; rd_pop = pop;
    ctl_wr = cw; ctl_wdata = cd; baud_tick = tk;
    @(posedge clk);
    #2;
    rx_vld = 1'b0; rd_pop = 1'b0; ctl_wr = 1'b0; baud_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  task automatic push1(input logic [7:0] d);
    step(1'b1, d, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic pop1();
    step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic ctl(input logic [7:0] cd);
    step(1'b0, 8'h00, 1'b0, 1'b1, cd, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all-R actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; rx_vld = 1'b0;
    rx_byte = '0; baud_tick = 1'b0; rd_pop = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1: values during reset
    check("R1", "rdy in reset", 32'(rd_ready), 0);
    check("R1", "ovr in reset", 32'(ovr_flag), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "rdy", 32'(rd_ready), 0);
    check("R1", "byte", 32'(rd_byte), 0);
    check("R1", "lvl", 32'(irq_level), 0);
    check("R1", "stale", 32'(irq_stale), 0);
    check("R1", "ovr", 32'(ovr_flag), 0);
    // R1: holding mode after reset, second load overruns
    push1(8'h5A);
    push1(8'h6B);
    check("R1", "holding cap ovr", 32'(ovr_flag), 1);
    check("R1", "holding head", 32'(rd_byte), 32'h5A);
    ctl(8'h02);

    // Vector table: R2 order, R4/R5 threshold 4 and 1, R10, R9
    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v].op)
        OP_PUSH: push1(VEC[v].din);
        OP_POP:  pop1();
        OP_BOTH: step(1'b1, VEC[v].din, 1'b1, 1'b0, 8'h00, 1'b0);
        default: ctl(VEC[v].din);
      endcase
      check("R2", $sformatf("vec%0d rdy", v), 32'(rd_ready), 32'(VEC[v].rdy));
      check("R2", $sformatf("vec%0d head", v), 32'(rd_byte), 32'(VEC[v].head));
      check("R4", $sformatf("vec%0d lvl", v), 32'(irq_level), 32'(VEC[v].lvl));
      check("R3", $sformatf("vec%0d ovr", v), 32'(ovr_flag), 32'(VEC[v].ovr));
    end

    // R4: threshold 14 boundary; R3 full drop; R10 pair on full
    ctl(8'hC1);
    for (int i = 0; i < 16; i++) begin
      push1(8'h10 + 8'(i));
      if (i == 12) check("R4", "lvl at 13", 32'(irq_level), 0);
      if (i == 13) check("R4", "lvl at 14", 32'(irq_level), 1);
    end
    check("R3", "no ovr at 16", 32'(ovr_flag), 0);
    push1(8'hEE);
    check("R3", "ovr on full", 32'(ovr_flag), 1);
    check("R3", "head unchanged", 32'(rd_byte), 32'h10);
    step(1'b1, 8'hF0, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R10", "pair on full head", 32'(rd_byte), 32'h11);
    check("R10", "pair keeps lvl", 32'(irq_level), 1);
    for (int k = 1; k <= 16; k++) begin
      check("R2", $sformatf("drain %0d", k), 32'(rd_byte),
            (k == 16) ? 32'hF0 : 32'(8'h10 + 8'(k)));
      pop1();
      check("R5", $sformatf("lvl after pop %0d", k), 32'(irq_level),
            ((16 - k) >= 14) ? 1 : 0);
    end
    check("R2", "drained", 32'(rd_ready), 0);
    check("R3", "ovr still set", 32'(ovr_flag), 1);
    ctl(8'hC3);
    check("R9", "flush clears ovr", 32'(ovr_flag), 0);

    // R4: threshold 8 boundary
    ctl(8'h81);
    for (int i = 0; i < 8; i++) begin
      push1(8'(i));
      if (i == 6) check("R4", "lvl at 7", 32'(irq_level), 0);
      if (i == 7) check("R4", "lvl at 8", 32'(irq_level), 1);
    end
    // R9: load in a flush cycle is discarded without overrun
    step(1'b1, 8'h99, 1'b0, 1'b1, 8'h83, 1'b0);
    check("R9", "flush empties", 32'(rd_ready), 0);
    check("R9", "flush load no ovr", 32'(ovr_flag), 0);

    // R9: mode change flushes; holding mode threshold is 1
    push1(8'h33);
    ctl(8'hC0);
    check("R9", "mode change flush", 32'(rd_ready), 0);
    push1(8'h11);
    check("R4", "holding lvl", 32'(irq_level), 1);
    push1(8'h22);
    check("R3", "holding drop ovr", 32'(ovr_flag), 1);
    check("R3", "holding head", 32'(rd_byte), 32'h11);
    pop1();
    check("R3", "holding empty", 32'(rd_ready), 0);
    ctl(8'h03);

    // R8: ticks while empty are ignored
    ticks(700);
    check("R8", "empty no stale", 32'(irq_stale), 0);
    // R6: window of 640 ticks
    push1(8'hAA);
    ticks(639);
    check("R6", "stale at 639", 32'(irq_stale), 0);
    ticks(1);
    check("R6", "stale at 640", 32'(irq_stale), 1);
    ticks(5);
    check("R6", "stale holds", 32'(irq_stale), 1);
    // R7: load restarts
    push1(8'hBB);
    check("R7", "load clears", 32'(irq_stale), 0);
    ticks(639);
    check("R7", "restart 639", 32'(irq_stale), 0);
    ticks(1);
    check("R7", "restart 640", 32'(irq_stale), 1);
    // R7: pop restarts
    pop1();
    check("R7", "pop clears", 32'(irq_stale), 0);
    ticks(639);
    check("R7", "pop restart 639", 32'(irq_stale), 0);
    ticks(1);
    check("R7", "pop restart 640", 32'(irq_stale), 1);
    // R9: flush clears stale
    ctl(8'h03);
    check("R9", "flush stale", 32'(irq_stale), 0);
    check("R9", "flush rdy", 32'(rd_ready), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule